// File: doc/BRIEF.md
# Strided Strip-Mining Address Generator

This block turns one vector memory operation of arbitrary length into a stream of element byte addresses. The operation is cut into strips no longer than the maximum vector length. Software supplies a base byte address, a signed stride counted in elements, and a total element count, then pulses `start`. The block then emits one byte address per accepted beat, together with the length of the strip that beat belongs to and markers for the first and last beats of each strip.

Strips are ordered so the odd-sized piece comes first. That piece is the count modulo the maximum vector length, and every later strip is full length. Each strip begins where the previous one ended, so the element index runs contiguously from 0 to count−1 across all strips. A zero-length leading piece, which occurs when the count is an exact multiple, is skipped and costs no beat.

The address output is a valid/ready stream. A beat is transferred on a rising clock edge where both `addr_valid` and `addr_ready` are high. While `addr_valid` is high and `addr_ready` is low, the address, strip length and both markers are held unchanged. `addr_valid` never drops before the beat is taken. The control pins `start`, `busy` and `done` are plain level/pulse signals.

Top module: `sagen_top`

## Requirements
- R1: After reset, `addr_valid`, `busy` and `done` are low.
- R2: Beat number i (0-based across the whole operation) carries byte address base + i·stride·ELEM_BYTES modulo 2^ADDR_W. The stride is two's complement, and ELEM_BYTES defaults to 8.
- R3: The first strip holds count mod MVL elements and every later strip holds MVL elements. `strip_len` shows the length of the strip the current beat belongs to.
- R4: When count mod MVL is 0, no beat is issued for the empty first strip, so the operation starts with a full strip. `strip_first` is high exactly on the first beat of each strip, and `strip_last` exactly on its last beat.
- R5: Once started, `addr_valid` stays high until the last beat is accepted. With `addr_ready` held high, one address is transferred every cycle, and exactly count beats are transferred in total.
- R6: While `addr_valid` is high and `addr_ready` is low, `addr`, `strip_len`, `strip_first` and `strip_last` keep their values.
- R7: `done` is high for exactly one cycle, the cycle after the edge that accepts the last beat. `busy` and `addr_valid` are low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored: the running sequence continues unchanged and no second sequence follows.
- R9: A start with a count of 0 issues no beat, and `done` pulses in the cycle after the start edge.
- R10: `addr_valid` rises in the cycle right after the edge that samples an accepted `start` with a non-zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| stride | input | STRIDE_W | Signed element stride |
| elem_count | input | N_W | Total number of elements |
| addr_valid | output | 1 | Address beat available |
| addr_ready | input | 1 | Consumer accepts the beat |
| addr | output | ADDR_W | Element byte address |
| strip_len | output | LEN_W | Length of the current strip |
| strip_first | output | 1 | First beat of a strip |
| strip_last | output | 1 | Last beat of a strip |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong element index or step register shows up as a mismatched address on the very beat where the fault occurs. The bench compares every accepted beat against the arithmetic model. A strip counter or remaining-strip count that is off shows as a wrong `strip_len` or misplaced marker within one strip. A wrong remaining-strip count also shows as a wrong total beat count, or as `done` arriving early or late, when the sequence ends. The bench sweeps every count over several multiples of a small MVL, with positive, negative and zero strides and with random back-pressure, so a hold violation is caught on the first stalled cycle.

// File: rtl/sagen_pkg.sv
package sagen_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_STRIDE_W   = 16;
  localparam int unsigned DEF_N_W        = 16;
  localparam int unsigned DEF_MVL        = 64;
  localparam int unsigned DEF_ELEM_BYTES = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/sagen_strip_ctl.sv
module sagen_strip_ctl #(
  parameter int unsigned N_W = 16,
  parameter int unsigned MVL = 64,
  localparam int unsigned LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_W-1:0]   count,
  input  logic             adv,
  input  logic             active,
  output logic [LEN_W-1:0] strip_len,
  output logic             strip_first,
  output logic             strip_last,
  output logic             final_beat
);
  localparam logic [N_W-1:0]   MVL_N   = N_W'(MVL);
  localparam logic [LEN_W-1:0] MVL_LEN = LEN_W'(MVL);

  logic [LEN_W-1:0] len_q, pos_q;
  logic [N_W-1:0]   left_q;
  logic [N_W-1:0]   rem_n, full_n;

  assign rem_n  = count % MVL_N;
  assign full_n = count / MVL_N;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      pos_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      pos_q <= '0;
      if (rem_n != '0) begin
        len_q  <= LEN_W'(rem_n);
        left_q <= full_n;
      end else begin
        len_q  <= MVL_LEN;
        left_q <= full_n - 1'b1;
      end
    end else if (adv) begin
      if (strip_last) begin
        pos_q  <= '0;
        len_q  <= MVL_LEN;
        left_q <= left_q - 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign strip_len   = len_q;
  assign strip_first = (pos_q == '0);
  assign strip_last  = (pos_q == len_q - 1'b1);
  assign final_beat  = strip_last && (left_q == '0);

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (len_q != '0) && (len_q <= MVL_LEN) && (pos_q < len_q));

  // R3
  full_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && strip_last && left_q != '0) |=> (len_q == MVL_LEN) && (pos_q == '0));
endmodule

// File: rtl/sagen_addr_acc.sv
module sagen_addr_acc #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned STRIDE_W   = 16,
  parameter int unsigned ELEM_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          base,
  input  logic signed [STRIDE_W-1:0] stride,
  input  logic                       adv,
  output logic [ADDR_W-1:0]          addr
);
  localparam logic [ADDR_W-1:0] EB = ADDR_W'(ELEM_BYTES);

  logic [ADDR_W-1:0] addr_q, step_q, step_d;

  assign step_d = ADDR_W'(stride) * EB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (load) begin
      addr_q <= base;
      step_q <= step_d;
    end else if (adv) begin
      addr_q <= addr_q + step_q;
    end
  end

  assign addr = addr_q;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> addr_q == $past(addr_q) + step_q);
endmodule

// File: rtl/sagen_top.sv
module sagen_top
  import sagen_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned STRIDE_W   = DEF_STRIDE_W,
  parameter int unsigned N_W        = DEF_N_W,
  parameter int unsigned MVL        = DEF_MVL,
  parameter int unsigned ELEM_BYTES = DEF_ELEM_BYTES,
  localparam int unsigned LEN_W     = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [N_W-1:0]      elem_count,
  output logic                addr_valid,
  input  logic                addr_ready,
  output logic [ADDR_W-1:0]   addr,
  output logic [LEN_W-1:0]    strip_len,
  output logic                strip_first,
  output logic                strip_last,
  output logic                busy,
  output logic                done
);
  run_state_t state_q;
  logic done_q, take, go, accept, final_beat;

  assign take   = start && (state_q == ST_IDLE);
  assign go     = take && (elem_count != '0);
  assign accept = (state_q == ST_RUN) && addr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take && elem_count == '0) begin
        done_q <= 1'b1;
      end else if (go) begin
        state_q <= ST_RUN;
      end else if (accept && final_beat) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  sagen_strip_ctl #(.N_W(N_W), .MVL(MVL)) i_strip (
    .clk(clk), .rst_n(rst_n), .load(go), .count(elem_count), .adv(accept),
    .active(state_q == ST_RUN), .strip_len(strip_len), .strip_first(strip_first),
    .strip_last(strip_last), .final_beat(final_beat)
  );

  sagen_addr_acc #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .ELEM_BYTES(ELEM_BYTES)) i_acc (
    .clk(clk), .rst_n(rst_n), .load(go), .base(base_addr), .stride(stride),
    .adv(accept), .addr(addr)
  );

  assign addr_valid = (state_q == ST_RUN);
  assign busy       = (state_q == ST_RUN);
  assign done       = done_q;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> addr_valid && $stable(addr) && $stable(strip_len)
      && $stable(strip_first) && $stable(strip_last));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  // R10
  start_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && elem_count != '0) |=> addr_valid);

  // R8
  keep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(addr_ready && strip_last && final_beat)) |=> busy);
endmodule

// File: tb/test_sagen_top.sv
module test_sagen_top;
  localparam int AW = 16, SW = 8, NW = 8, M = 4, EB = 8;
  localparam int LW = $clog2(M + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, addr_ready = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [SW-1:0] stride = '0;
  logic [NW-1:0] elem_count = '0;
  logic addr_valid, strip_first, strip_last, busy, done;
  logic [AW-1:0] addr;
  logic [LW-1:0] strip_len;

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sagen_top #(.ADDR_W(AW), .STRIDE_W(SW), .N_W(NW), .MVL(M), .ELEM_BYTES(EB)) i_sagen_top (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .stride(stride),
    .elem_count(elem_count), .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .strip_len(strip_len), .strip_first(strip_first), .strip_last(strip_last),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  // mode 0: ready always high, 1: random ready; poke = beat index at which a stray start is given
  task automatic run(input int b, input int s, input int n, input int mode, input int poke);
    int i, r, len, pos, guard;
    logic [AW-1:0] p_addr;
    logic [LW-1:0] p_len;
    logic p_f, p_l, stalled;
    @(negedge clk);
    base_addr = AW'(b); stride = SW'(s); elem_count = NW'(n); start = 1'b1;
    addr_ready = (mode == 0);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(addr_valid == 1'b0, "R9", int'(addr_valid), 0);
      chk(done == 1'b1, "R9", int'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R9", int'(done), 0);
      return;
    end
    chk(addr_valid == 1'b1, "R10", int'(addr_valid), 1);
    i = 0; stalled = 1'b0; guard = 0;
    p_addr = '0; p_len = '0; p_f = 1'b0; p_l = 1'b0;
    r = n % M;
    while (i < n && guard < 4000) begin
      guard++;
      addr_ready = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      if (i == poke && poke >= 0) begin
        start = 1'b1; base_addr = 16'h7777; stride = 8'd5; elem_count = 8'd9;
      end else begin
        start = 1'b0;
      end
      chk(addr_valid == 1'b1 && done == 1'b0, "R5", int'(addr_valid), 1);
      if (stalled)
        chk(addr == p_addr && strip_len == p_len && strip_first == p_f && strip_last == p_l,
            "R6", int'(addr), int'(p_addr));
      if (r != 0 && i < r) begin len = r; pos = i; end
      else begin len = M; pos = (i - r) % M; end
      chk(addr == AW'(b + i * s * EB), "R2", int'(addr), int'(AW'(b + i * s * EB)));
      chk(int'(strip_len) == len, "R3", int'(strip_len), len);
      chk(strip_first == (pos == 0) && strip_last == (pos == len - 1), "R4",
          int'({strip_first, strip_last}), int'({pos == 0, pos == len - 1}));
      p_addr = addr; p_len = strip_len; p_f = strip_first; p_l = strip_last;
      stalled = !addr_ready;
      if (addr_ready) i++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(i == n, "R5", i, n);
    chk(done == 1'b1 && busy == 1'b0 && addr_valid == 1'b0, "R7",
        int'({done, busy, addr_valid}), 4);
    @(negedge clk);
    chk(done == 1'b0, "R7", int'(done), 0);
    if (poke >= 0) begin
      @(negedge clk);
      chk(addr_valid == 1'b0 && busy == 1'b0, "R8", int'(addr_valid), 0);
    end
  endtask

  initial begin
    #5;
    chk(addr_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", int'({addr_valid, busy, done}), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk(addr_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", int'({addr_valid, busy, done}), 0);
    for (int n = 0; n <= 13; n++) begin
      run(16'h1000, 1, n, 0, -1);
      run(16'hFFF0, 3, n, 1, -1);
      run(16'h0040, -2, n, 1, -1);
      run(16'h2345, 0, n, 0, -1);
    end
    run(16'h0100, 127, 11, 1, -1);
    run(16'h8000, -128, 12, 0, -1);
    // R8 stray start mid-run
    run(16'h0300, 2, 10, 0, 3);
    run(16'h0500, -1, 8, 1, 5);
    summary();
  end
endmodule